// File: doc/BRIEF.md
# Serial-to-Octet Deserializer with Window Slip

This block turns a retimed serial bit stream into 8-bit parallel words. The first register captures each incoming bit on the bit clock and regenerates it. A tree of 1:2 splitting stages then builds the word: two stages form a 1:4 section and a final 1:2 stage completes it. An output register presents all eight bits at once, together with a one-cycle valid strobe.

The octet boundary is not known at start-up. A cell-delineation search downstream looks for valid header check fields. Each time that search gives up on the current alignment, it pulses a slip request. Each request drops one serial bit before it enters the tree, which moves the 8-bit window one position later in the stream. Eight slips bring the window back to its first alignment. The word that straddles a slip is incomplete, so its strobe is withheld. The data path itself is never stalled.

Top module: `octet_deser`

## Requirements
- R1: Each word holds 8 consecutive accepted serial bits. The earliest bit received is on word_o[7] and the latest is on word_o[0].
- R2: word_vld_o is a single-cycle pulse, one for every 8 accepted bits. It is high after the fourth rising edge that follows the edge that sampled the word's last bit.
- R3: At a rising edge where slip_req is high, the ser_din value sampled at that edge is discarded, so the window moves one bit later.
- R4: The strobe of the word that contains the first bit accepted after a discard is suppressed. The word after it is emitted normally.
- R5: After eight slips taken one at a time, words are aligned again to the boundaries of a byte-aligned input stream.
- R6: While rst is high, and until 8 bits have been accepted after rst falls, word_vld_o stays low.
- R7: word_o changes only in a cycle in which word_vld_o is high. Between strobes it holds the last emitted word, and it is 0 after reset.
- R8: slip_req held high over N consecutive edges discards N bits. Only one word is suppressed for that whole run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock; every rising edge samples one serial bit |
| rst | input | 1 | Synchronous active-high reset |
| ser_din | input | 1 | Serial data in |
| slip_req | input | 1 | Discard the bit sampled at this edge (window slip) |
| word_o | output | 8 | Assembled parallel word, first bit in the MSB |
| word_vld_o | output | 1 | One-cycle strobe marking a new complete word |

## Verification
The assertions take for granted that the bench drives rst high from time zero. They also assume that every input is settled at each rising edge. Beyond that they place no limit on slip_req: single pulses, long runs and slips that land on a word boundary must all keep the spacing and suppression properties. To meet this, the stimulus changes inputs only on the falling edge and holds reset for several cycles at the start. It also mixes random slip pulses and runs with byte-aligned directed streams.

// File: rtl/sdm_pkg.sv
package sdm_pkg;
  // Side-band tag that travels with data through the split tree.
  typedef struct packed {
    logic vld;  // this beat carries data
    logic tnt;  // beat includes a bit taken right after a slip
  } sdm_tag_t;
endpackage

// File: rtl/sdm_regen.sv
module sdm_regen
  import sdm_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     ser_din,
  input  logic     slip_req,
  output logic     bit_q,
  output sdm_tag_t tag_q
);
  logic pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_q  <= 1'b0;
      tag_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      bit_q <= ser_din;
      if (slip_req) begin
        tag_q.vld <= 1'b0;
        tag_q.tnt <= 1'b0;
        pend_q    <= 1'b1;
      end else begin
        tag_q.vld <= 1'b1;
        tag_q.tnt <= pend_q;
        pend_q    <= 1'b0;
      end
    end
  end

  AST_SLIP_DROPS: assert property (@(posedge clk) disable iff (rst)
    slip_req |=> !tag_q.vld);  // R3

  AST_SLIP_MARKS_NEXT: assert property (@(posedge clk) disable iff (rst)
    ($past(slip_req) && !$past(rst) && !slip_req) |=> (tag_q.vld && tag_q.tnt));  // R4
endmodule

// File: rtl/sdm_split2.sv
module sdm_split2
  import sdm_pkg::*;
#(
  parameter int IN_W = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   in_dat,
  input  sdm_tag_t          in_tag,
  output logic [2*IN_W-1:0] out_dat,
  output sdm_tag_t          out_tag
);
  localparam int OUT_W = 2 * IN_W;

  logic [IN_W-1:0] half_q;
  logic            half_tnt_q;
  logic            ph_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q     <= '0;
      half_tnt_q <= 1'b0;
      ph_q       <= 1'b0;
      out_dat    <= '0;
      out_tag    <= '0;
    end else begin
      out_tag.vld <= 1'b0;
      if (in_tag.vld) begin
        if (!ph_q) begin
          half_q     <= in_dat;
          half_tnt_q <= in_tag.tnt;
          ph_q       <= 1'b1;
        end else begin
          out_dat     <= OUT_W'({half_q, in_dat});
          out_tag.vld <= 1'b1;
          out_tag.tnt <= half_tnt_q | in_tag.tnt;
          ph_q        <= 1'b0;
        end
      end
    end
  end

  AST_PAIR_SOURCE: assert property (@(posedge clk) disable iff (rst)
    out_tag.vld |-> $past(in_tag.vld));  // R2

  AST_PAIR_SPACED: assert property (@(posedge clk) disable iff (rst)
    out_tag.vld |=> !out_tag.vld);  // R2
endmodule

// File: rtl/sdm_out_sync.sv
module sdm_out_sync
  import sdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] in_dat,
  input  sdm_tag_t          in_tag,
  output logic [WORD_W-1:0] word_q,
  output logic              vld_q
);
  logic take;
  assign take = in_tag.vld & ~in_tag.tnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= take;
      if (take) word_q <= in_dat;
    end
  end

  AST_TAINT_DROP: assert property (@(posedge clk) disable iff (rst)
    (in_tag.vld && in_tag.tnt) |=> !vld_q);  // R4

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (rst)
    !$stable(word_q) |-> vld_q);  // R7

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (rst)
    vld_q |=> !vld_q);  // R2
endmodule

// File: rtl/octet_deser.sv
module octet_deser
  import sdm_pkg::*;
#(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_din,
  input  logic              slip_req,
  output logic [WORD_W-1:0] word_o,
  output logic              word_vld_o
);
  localparam int LEVELS = $clog2(WORD_W);

  logic     bit_q;
  sdm_tag_t tag_q;

  // Stage 0: retime / regenerate, apply slip requests.
  sdm_regen u_regen (
    .clk      (clk),
    .rst      (rst),
    .ser_din  (ser_din),
    .slip_req (slip_req),
    .bit_q    (bit_q),
    .tag_q    (tag_q)
  );

  // Tree of 1:2 stages, each doubling the word width.
  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int IW = 1 << l;
    logic [IW-1:0]   i_dat;
    sdm_tag_t        i_tag;
    logic [2*IW-1:0] o_dat;
    sdm_tag_t        o_tag;

    if (l == 0) begin : g_head
      assign i_dat = bit_q;
      assign i_tag = tag_q;
    end else begin : g_body
      assign i_dat = g_lvl[l-1].o_dat;
      assign i_tag = g_lvl[l-1].o_tag;
    end

    sdm_split2 #(.IN_W(IW)) u_split (
      .clk     (clk),
      .rst     (rst),
      .in_dat  (i_dat),
      .in_tag  (i_tag),
      .out_dat (o_dat),
      .out_tag (o_tag)
    );
  end

  // Output resynchronisation: all bits update together.
  sdm_out_sync #(.WORD_W(WORD_W)) u_out (
    .clk    (clk),
    .rst    (rst),
    .in_dat (g_lvl[LEVELS-1].o_dat),
    .in_tag (g_lvl[LEVELS-1].o_tag),
    .word_q (word_o),
    .vld_q  (word_vld_o)
  );

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !word_vld_o);  // R6
endmodule

// File: tb/octet_deser_test.sv
module octet_deser_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_din = 1'b0;
  logic       slip_req = 1'b0;
  logic [7:0] word_o;
  logic       word_vld_o;

  always #2.5 clk = ~clk;  // 200 MHz

  octet_deser uut (
    .clk        (clk),
    .rst        (rst),
    .ser_din    (ser_din),
    .slip_req   (slip_req),
    .word_o     (word_o),
    .word_vld_o (word_vld_o)
  );

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // expectation pipeline: entry i is checked 4 edges after it is made
  bit    p_vld [5];
  logic [7:0] p_dat [5];
  string p_tag [5];

  int    m_cnt = 0;
  int    m_since_rst = 0;
  logic [7:0] m_acc = '0;
  bit    m_t = 1'b0;
  bit    m_pend = 1'b0;
  string cur_tag = "R1";
  logic [7:0] prev_word = '0;

  initial for (int i = 0; i < 5; i++) begin
    p_vld[i] = 1'b0; p_dat[i] = '0; p_tag[i] = "R6";
  end

  function automatic void fail_msg(string req, string what, logic [7:0] act, logic [7:0] exp);
    $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
  endfunction

  task automatic step(input logic d, input logic s, input logic r);
    @(negedge clk);
    // check results of the edge just passed
    n_chk++;
    if (word_vld_o !== p_vld[0]) begin
      n_fail++;
      fail_msg(p_tag[0], "word_vld_o", {7'd0, word_vld_o}, {7'd0, p_vld[0]});
    end
    if (p_vld[0]) begin
      n_chk++;
      if (word_o !== p_dat[0]) begin
        n_fail++;
        fail_msg(p_tag[0], "word_o", word_o, p_dat[0]);
      end
    end else begin
      n_chk++;
      if (word_o !== prev_word) begin
        n_fail++;
        fail_msg("R7", "word_o held", word_o, prev_word);
      end
    end
    prev_word = word_o;
    for (int i = 0; i < 4; i++) begin
      p_vld[i] = p_vld[i+1]; p_dat[i] = p_dat[i+1]; p_tag[i] = p_tag[i+1];
    end
    // model the coming edge
    p_vld[4] = 1'b0; p_dat[4] = '0; p_tag[4] = (m_since_rst < 9) ? "R6" : "R2";
    if (r) begin
      m_cnt = 0; m_t = 1'b0; m_pend = 1'b0; m_since_rst = 0; p_tag[4] = "R6";
    end else if (s) begin
      m_pend = 1'b1;
      if (m_since_rst >= 9) p_tag[4] = "R3";
    end else begin
      m_acc = {m_acc[6:0], d};
      if (m_cnt == 0) m_t = m_pend; else m_t = m_t | m_pend;
      m_pend = 1'b0;
      m_cnt++;
      m_since_rst++;
      if (m_cnt == 8) begin
        m_cnt = 0;
        p_vld[4] = !m_t;
        p_dat[4] = m_acc;
        p_tag[4] = m_t ? "R4" : cur_tag;
      end
    end
    ser_din = d; slip_req = s; rst = r;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) step(b[i], 1'b0, 1'b0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%02h expected=%02h", 8'h00, 8'h01);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    // R6: reset held, then early cycles must stay quiet
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b1);
    // R1: directed byte-aligned patterns, MSB first
    cur_tag = "R1";
    send_byte(8'hA5); send_byte(8'h3C); send_byte(8'h81); send_byte(8'hFF);
    send_byte(8'h00); send_byte(8'h5A);
    // R3 and R4: one slip mid-word
    cur_tag = "R3";
    send_byte(8'hC3);
    step(1'b1, 1'b0, 1'b0); step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 6; i++) send_byte(8'h69 + 8'(i));
    // R5: realign with byte-aligned stream and eight single slips
    for (int i = 0; i < 7; i++) step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) send_byte(8'h12 + 8'(i));
    for (int k = 0; k < 8; k++) begin
      step(1'b0, 1'b1, 1'b0);
      send_byte(8'h40 + 8'(k)); send_byte(8'hB0 + 8'(k));
    end
    cur_tag = "R5";
    for (int i = 0; i < 6; i++) send_byte(8'hD0 + 8'(i));
    // R8: a run of three slips, only one word suppressed
    cur_tag = "R8";
    step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0); step(1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 5; i++) send_byte(8'h27 * 8'(i + 1));
    // R2: random bits with random slips and runs
    cur_tag = "R2";
    for (int i = 0; i < 4000; i++) begin
      logic s;
      s = (($urandom % 16) == 0);
      step(logic'($urandom % 2), s, 1'b0);
    end
    for (int i = 0; i < 8; i++) step(1'b0, 1'b0, 1'b0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule